// File: doc/BRIEF.md
# Digitally Filtered PLL Lock Detector

This block produces a registered lock indication for a frequency synthesizer. It receives the UP and DOWN pulses of a phase-frequency detector, measures in reference-oscillator clocks how long either pulse is active during each phase comparison cycle, and compares that width with a window of two reference periods. A single-cycle strobe closes every comparison cycle. The block filters the per-cycle verdict over consecutive cycles. Lock is reported only after a run of good cycles and is withdrawn at the first bad one.

The detector pulses are asynchronous to the measuring clock, so each one passes through a two-flop synchronizer first. A power-down input forces the output high whenever the synthesizer is put to sleep. When power-down is released, the filter starts again from an empty run.

Top module: `lock_detector`

## Requirements
- R1: A comparison cycle is good when its measured error is below 2 reference clocks. An error of 2 or more makes the cycle bad.
- R2: The error of a cycle is the number of reference clocks in which the synchronized UP or the synchronized DOWN (or both) is high. A clock where both are high counts once. Each input reaches the measurement two clocks after it is driven.
- R3: The error measurement saturates at ERR_MAX and never wraps. A pulse of ERR_MAX+2 clocks is therefore still judged bad.
- R4: `lock_o` rises one clock after the strobe of the fourth consecutive good cycle, and not after the third.
- R5: A strobe that closes a bad cycle drives `lock_o` low on the next clock and restarts the run of good cycles from zero.
- R6: Outside power-down, `lock_o` changes only on the clock that follows a strobe.
- R7: While `pwrdn_i` is high, `lock_o` is high from the next clock on, whatever the detector inputs and the strobe do.
- R8: One clock after `pwrdn_i` falls, `lock_o` is low. The run of good cycles starts again from zero.
- R9: While `rst_n` is low, `lock_o` is low on the next clock and the run and error counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-oscillator clock, used for measurement |
| rst_n | input | 1 | Synchronous reset, active low |
| up_i | input | 1 | UP pulse from the phase detector (asynchronous) |
| dn_i | input | 1 | DOWN pulse from the phase detector (asynchronous) |
| cmp_strobe_i | input | 1 | One-clock marker that closes a comparison cycle |
| pwrdn_i | input | 1 | Power-down; forces the lock output high |
| lock_o | output | 1 | Registered, filtered lock indication |

## Verification
The filter's strobe-time verdict and the power-down override can act on the same clock. So can the release of power-down and a strobe that closes a cycle. The bench provokes the first case with frames whose pulses are wide and whose strobe arrives while power-down is held. It expects `lock_o` high and a run that restarts from zero afterwards. For the second case, the bench releases power-down at the start of a frame and checks that `lock_o` is low by the second clock. Four further good frames must then pass before lock returns.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  // Saturating increment of the error width by one active clock.
  function automatic int unsigned err_step(input int unsigned cnt,
                                           input logic active,
                                           input int unsigned max_val);
    if (!active)         return cnt;
    if (cnt >= max_val)  return max_val;
    return cnt + 1;
  endfunction

  // Cycle verdict: true when the measured width is inside the window.
  function automatic logic in_window(input int unsigned width,
                                     input int unsigned window);
    return width < window;
  endfunction

  // Saturating run-length advance.
  function automatic int unsigned run_step(input int unsigned run,
                                           input int unsigned limit);
    return (run >= limit) ? limit : run + 1;
  endfunction

endpackage

// File: rtl/pulse_sync.sv
module pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/err_meter.sv
module err_meter
  import lockdet_pkg::*;
#(
  parameter int ERR_MAX = 15,
  parameter int WINDOW  = 2,
  localparam int ERR_W  = $clog2(ERR_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             active_i,
  input  logic             strobe_i,
  output logic [ERR_W-1:0] err_cnt_o,
  output logic [ERR_W-1:0] err_total_o,
  output logic             cyc_good_o
);
  logic [ERR_W-1:0] err_q;
  logic [ERR_W-1:0] err_total;

  always_comb begin
    err_total = ERR_W'(err_step(int'(err_q), active_i, ERR_MAX));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    err_q <= '0;
    else if (clear_i || strobe_i)  err_q <= '0;
    else                           err_q <= err_total;
  end

  assign err_cnt_o   = err_q;
  assign err_total_o = err_total;
  assign cyc_good_o  = in_window(int'(err_total), WINDOW);
endmodule

// File: rtl/lock_filter.sv
module lock_filter
  import lockdet_pkg::*;
#(
  parameter int LOCK_CYCLES = 4,
  localparam int RUN_W      = $clog2(LOCK_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwrdn_i,
  input  logic             strobe_i,
  input  logic             good_i,
  output logic [RUN_W-1:0] run_o,
  output logic             state_o,
  output logic             lock_o
);
  logic [RUN_W-1:0] run_q, run_d;
  logic             state_q, state_d;
  logic             lock_q;

  always_comb begin
    run_d   = run_q;
    state_d = state_q;
    if (pwrdn_i) begin
      run_d   = '0;
      state_d = 1'b0;
    end else if (strobe_i) begin
      if (good_i) begin
        run_d   = RUN_W'(run_step(int'(run_q), LOCK_CYCLES));
        state_d = (int'(run_d) >= LOCK_CYCLES);
      end else begin
        run_d   = '0;
        state_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= '0;
      state_q <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      run_q   <= run_d;
      state_q <= state_d;
      lock_q  <= pwrdn_i | state_d;
    end
  end

  assign run_o   = run_q;
  assign state_o = state_q;
  assign lock_o  = lock_q;
endmodule

// File: rtl/lock_detector.sv
module lock_detector
  import lockdet_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WINDOW      = 2,
  parameter int LOCK_CYCLES = 4,
  parameter int ERR_MAX     = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_i,
  input  logic dn_i,
  input  logic cmp_strobe_i,
  input  logic pwrdn_i,
  output logic lock_o
);
  localparam int ERR_W = $clog2(ERR_MAX + 1);
  localparam int RUN_W = $clog2(LOCK_CYCLES + 1);

  logic [1:0]       raw_pulse;
  logic [1:0]       sync_pulse;
  logic             pulse_active;
  logic [ERR_W-1:0] err_cnt;
  logic [ERR_W-1:0] err_total;
  logic             cyc_good;
  logic [RUN_W-1:0] run_cnt;
  logic             lock_state;

  assign raw_pulse = {dn_i, up_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (raw_pulse[g]),
      .q_sync  (sync_pulse[g])
    );
  end

  assign pulse_active = |sync_pulse;

  err_meter #(.ERR_MAX(ERR_MAX), .WINDOW(WINDOW)) u_meter (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (pwrdn_i),
    .active_i    (pulse_active),
    .strobe_i    (cmp_strobe_i),
    .err_cnt_o   (err_cnt),
    .err_total_o (err_total),
    .cyc_good_o  (cyc_good)
  );

  lock_filter #(.LOCK_CYCLES(LOCK_CYCLES)) u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwrdn_i  (pwrdn_i),
    .strobe_i (cmp_strobe_i),
    .good_i   (cyc_good),
    .run_o    (run_cnt),
    .state_o  (lock_state),
    .lock_o   (lock_o)
  );
endmodule

// File: rtl/lock_detector_chk.sv
module lock_detector_chk #(
  parameter int ERR_W       = 4,
  parameter int RUN_W       = 3,
  parameter int ERR_MAX     = 15,
  parameter int LOCK_CYCLES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmp_strobe_i,
  input logic             pwrdn_i,
  input logic             lock_o,
  input logic             pulse_active,
  input logic             cyc_good,
  input logic [ERR_W-1:0] err_cnt,
  input logic [RUN_W-1:0] run_cnt
);
  AST_PWRDN_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn_i |=> lock_o); // R7

  AST_BAD_CYCLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_strobe_i && !cyc_good && !pwrdn_i) |=> (!lock_o && run_cnt == '0)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(err_cnt) == ERR_MAX && pulse_active && !cmp_strobe_i && !pwrdn_i)
      |=> int'(err_cnt) == ERR_MAX); // R3

  AST_RISE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_strobe_i && cyc_good && !pwrdn_i && int'(run_cnt) < LOCK_CYCLES - 1)
      |=> !lock_o); // R4

  AST_RELEASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwrdn_i) && !cmp_strobe_i) |=> !lock_o); // R8

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_strobe_i && !pwrdn_i && !$past(pwrdn_i)) |=> $stable(lock_o)); // R6
endmodule

bind lock_detector lock_detector_chk #(
  .ERR_W(ERR_W), .RUN_W(RUN_W), .ERR_MAX(ERR_MAX), .LOCK_CYCLES(LOCK_CYCLES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmp_strobe_i (cmp_strobe_i),
  .pwrdn_i      (pwrdn_i),
  .lock_o       (lock_o),
  .pulse_active (pulse_active),
  .cyc_good     (cyc_good),
  .err_cnt      (err_cnt),
  .run_cnt      (run_cnt)
);

// File: tb/lock_detector_bench.sv
module lock_detector_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 2;
  localparam int NEED       = 4;
  localparam int SATV       = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_i = 1'b0, dn_i = 1'b0, cmp_strobe_i = 1'b0, pwrdn_i = 1'b0;
  logic lock_o;

  int n_chk = 0;
  int n_fail = 0;
  int run_m = 0;
  bit state_m = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lock_detector u_lock_detector (
    .clk(clk), .rst_n(rst_n), .up_i(up_i), .dn_i(dn_i),
    .cmp_strobe_i(cmp_strobe_i), .pwrdn_i(pwrdn_i), .lock_o(lock_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: lock_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Bench model of the error width: union of the two pulses, saturating.
  function automatic int width_of(input int len, input int us, input int uw,
                                  input int ds, input int dw);
    int w = 0;
    for (int i = 0; i < len; i++) begin
      if ((i >= us && i < us + uw) || (i >= ds && i < ds + dw))
        w = (w >= SATV) ? SATV : w + 1;
    end
    return w;
  endfunction

  // One comparison cycle of len clocks; strobe on the last clock.
  task automatic frame(input string req, input int len, input int us, input int uw,
                       input int ds, input int dw, input bit pd);
    bit prev_state = state_m;
    int w = width_of(len, us, uw, ds, dw);
    if (pd) begin
      run_m = 0; state_m = 1'b0;
    end else if (w < WIN) begin
      run_m = (run_m >= NEED) ? NEED : run_m + 1;
      state_m = (run_m >= NEED);
    end else begin
      run_m = 0; state_m = 1'b0;
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 2) check(pd ? "R7" : "R6/R8", lock_o, pd ? 1'b1 : prev_state);
      up_i = (i >= us && i < us + uw);
      dn_i = (i >= ds && i < ds + dw);
      cmp_strobe_i = (i == len - 1);
      pwrdn_i = pd;
    end
    @(negedge clk);
    cmp_strobe_i = 1'b0;
    up_i = 1'b0; dn_i = 1'b0;
    check(req, lock_o, pd ? 1'b1 : state_m);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R9", lock_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", lock_o, 1'b0);

    // R4: three good frames stay low, the fourth raises lock.
    frame("R4", 16, 3, 1, 0, 0, 0);
    frame("R4", 16, 0, 0, 4, 1, 0);
    frame("R4", 16, 3, 1, 3, 1, 0);
    frame("R4", 16, 0, 0, 0, 0, 0);
    frame("R4", 16, 5, 1, 0, 0, 0);
    // R1: width exactly 2 is bad.
    frame("R1", 16, 3, 2, 0, 0, 0);
    // R2: two separate 1-clock pulses make width 2 -> bad.
    repeat (4) frame("R2", 16, 2, 1, 0, 0, 0);
    frame("R2", 16, 2, 1, 6, 1, 0);
    // R2: fully overlapped pulses count once.
    repeat (4) frame("R2", 16, 4, 1, 4, 1, 0);
    frame("R2", 16, 4, 2, 5, 1, 0);
    // R3: a 17-clock pulse would wrap to 1 without saturation.
    repeat (4) frame("R3", 16, 0, 0, 0, 0, 0);
    frame("R3", 32, 2, 17, 0, 0, 0);
    // R7 with a bad cycle during power-down, then R8 release.
    frame("R7", 16, 1, 8, 2, 8, 1);
    frame("R7", 16, 0, 0, 0, 0, 1);
    repeat (5) frame("R8", 16, 0, 0, 0, 0, 0);

    for (int k = 0; k < 300; k++) begin
      int sel = $urandom_range(0, 9);
      int us = $urandom_range(1, 6);
      int ds = $urandom_range(1, 6);
      int uw = (sel < 7) ? $urandom_range(0, 1) : $urandom_range(0, 5);
      int dw = (sel < 5) ? 0 : $urandom_range(0, 2);
      bit pd = ($urandom_range(0, 19) == 0);
      frame("R5", 16, us, uw, ds, dw, pd);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule